// File: doc/BRIEF.md
# Per-Pin Event Replay Sequencer

This block produces the waveform state of a single tester pin from a list of timestamped state changes held in local storage. A host port loads up to sixteen short sequences. Each sequence has up to eight entries, and each entry pairs a target pin state with the fine tick at which the pin enters that state.

At every test period the shared timing system sends three things: a period-start pulse, a vernier that shifts the start of the period by a number of fine ticks, and a selection code that acts as the test vector. The block latches the selected sequence. It then walks the entries one per tick and changes the pin state when the tick count since the period start reaches the vernier plus the entry's time.

The outputs are a drive value, a drive enable and a two-bit compare mode for the comparator path. A sticky error flag reports malformed sequences. A sticky overrun flag reports a period that was cut short. Each pin instance runs on its own and stays aligned with the other pins only through the shared clock, period pulse and selection code. In this model one clock cycle is one fine tick.

Top module: `pin_event_seq`

## Requirements
- R1: After reset, drive_val, drive_en, cmp_mode (0 = idle), seq_error and overrun are all 0.
- R2: A host write with host_we=1 stores host_wdata at host_addr. host_addr is {sequence[3:0], slot[2:0]}. host_wdata is {last[11], state[10:8], time[7:0]}. At a period start, vec_sel picks the sequence that is replayed, starting from slot 0.
- R3: An entry with time t, replayed with vernier v, shows on the outputs v+t+1 clocks after the clock edge that captured period_start. Example: the entries drive-high@1, drive-low@8, drive-high@13, drive-low@18 with v=0 give a drive_val that rises after edge 2, falls after edge 9, rises after edge 14 and falls after edge 19.
- R4: State code 0 sets drive_val=0 and drive_en=1. Code 1 sets drive_val=1 and drive_en=1. Code 2 clears drive_en and leaves drive_val unchanged.
- R5: Code 3 sets cmp_mode=1 (expect high). Code 4 sets cmp_mode=2 (expect low). Code 5 sets cmp_mode=3 (expect high impedance). Code 6 sets cmp_mode=0 (idle). None of these codes changes drive_val or drive_en.
- R6: At most one entry is applied per clock. Replay stops after the entry whose last flag is set, or after slot 7. The pin state is held across periods until an entry changes it.
- R7: An entry is skipped and has no effect on the outputs if its time is not greater than the time of the last applied entry in the same period, or if its code is 7. A skipped entry uses one clock and sets seq_error, which stays set until reset. An entry is applied on the first clock it is examined at which the tick count is at least v+t.
- R8: If period_start arrives while a sequence is still replaying, the remaining entries are dropped, including one that is due in that cycle. overrun is then set and stays set until reset, and the new sequence starts.
- R9: If period_start arrives after the previous sequence has finished, overrun does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; one cycle is one fine tick |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe for the sequence store |
| host_addr | input | 7 | Write address {sequence, slot} |
| host_wdata | input | 12 | Entry {last, state, time} |
| period_start | input | 1 | Period-zero pulse |
| vernier | input | 4 | Fine-tick offset of the period start |
| vec_sel | input | 4 | Sequence selection for this period |
| drive_val | output | 1 | Logic level driven to the pin |
| drive_en | output | 1 | Driver enable |
| cmp_mode | output | 2 | Compare mode: 0 idle, 1 high, 2 low, 3 high impedance |
| seq_error | output | 1 | Sticky malformed-sequence flag |
| overrun | output | 1 | Sticky cut-short-period flag |

## Verification
An entry with time t and vernier v is due at the outputs in the cycle after edge v+t+1, counted from the edge that captured period_start. The error flag is due one edge after the skipped entry is examined, and the overrun flag one edge after the interrupting pulse. The directed checks wait that exact number of edges and sample on the following falling edge, one cycle before and one cycle after each change. A behavioural model in the bench updates on every rising edge and is compared with all five outputs on every falling edge.

// File: rtl/pes_pkg.sv
package pes_pkg;
    parameter int NUM_SEQ = 16;
    parameter int SEQ_LEN = 8;
    parameter int TIME_W  = 8;
    parameter int VERN_W  = 4;

    localparam int SEL_W   = $clog2(NUM_SEQ);
    localparam int IDX_W   = $clog2(SEQ_LEN);
    localparam int ADDR_W  = SEL_W + IDX_W;
    localparam int DEPTH   = NUM_SEQ * SEQ_LEN;
    localparam int ENTRY_W = TIME_W + 4;
    localparam int TICK_W  = TIME_W + 2;

    typedef enum logic [2:0] {
        EV_DRV_LO  = 3'd0,
        EV_DRV_HI  = 3'd1,
        EV_DRV_OFF = 3'd2,
        EV_TST_HI  = 3'd3,
        EV_TST_LO  = 3'd4,
        EV_TST_Z   = 3'd5,
        EV_TST_END = 3'd6,
        EV_INVALID = 3'd7
    } ev_code_e;

    typedef enum logic [1:0] {
        CMP_IDLE = 2'd0,
        CMP_HI   = 2'd1,
        CMP_LO   = 2'd2,
        CMP_Z    = 2'd3
    } cmp_mode_e;

    typedef struct packed {
        logic              last;
        ev_code_e          code;
        logic [TIME_W-1:0] tstamp;
    } entry_t;
endpackage

// File: rtl/pes_seq_store.sv
module pes_seq_store
    import pes_pkg::*;
(
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ENTRY_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output entry_t            rd_entry
);
    logic [ENTRY_W-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store_q[wr_addr] <= wr_data;
        end
    end

    always_comb begin
        rd_entry = entry_t'(store_q[rd_addr]);
    end
endmodule

// File: rtl/pes_sequencer.sv
module pes_sequencer
    import pes_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              period_start,
    input  logic [VERN_W-1:0] vernier,
    input  logic [SEL_W-1:0]  vec_sel,
    output logic [ADDR_W-1:0] rd_addr,
    input  entry_t            rd_entry,
    output logic              evt_valid,
    output ev_code_e          evt_code,
    output logic              seq_error,
    output logic              overrun
);
    typedef struct packed {
        logic              active;
        logic [SEL_W-1:0]  sel;
        logic [IDX_W-1:0]  idx;
        logic [TICK_W-1:0] tick;
        logic [VERN_W-1:0] vern;
        logic              have_prev;
        logic [TIME_W-1:0] prev_time;
        logic              err;
        logic              ovr;
    } seq_st_t;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SEQ_LEN - 1);

    seq_st_t           st_d, st_q;
    logic [TICK_W-1:0] target;
    logic              bad_entry;
    logic              due;

    always_comb begin
        target    = TICK_W'(st_q.vern) + TICK_W'(rd_entry.tstamp);
        bad_entry = (rd_entry.code == EV_INVALID) ||
                    (st_q.have_prev && (rd_entry.tstamp <= st_q.prev_time));
        due       = (st_q.tick >= target);

        st_d      = st_q;
        evt_valid = 1'b0;
        evt_code  = rd_entry.code;

        if (period_start) begin
            if (st_q.active) begin
                st_d.ovr = 1'b1;
            end
            st_d.active    = 1'b1;
            st_d.sel       = vec_sel;
            st_d.idx       = '0;
            st_d.tick      = '0;
            st_d.vern      = vernier;
            st_d.have_prev = 1'b0;
            st_d.prev_time = '0;
        end else if (st_q.active) begin
            if (bad_entry || due) begin
                if (bad_entry) begin
                    st_d.err = 1'b1;
                end else begin
                    evt_valid      = 1'b1;
                    st_d.have_prev = 1'b1;
                    st_d.prev_time = rd_entry.tstamp;
                end
                if (rd_entry.last || (st_q.idx == LAST_IDX)) begin
                    st_d.active = 1'b0;
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                end
            end
            st_d.tick = st_q.tick + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_addr   = {st_q.sel, st_q.idx};
    assign seq_error = st_q.err;
    assign overrun   = st_q.ovr;

    p_ovr_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (period_start && st_q.active) |=> st_q.ovr);

    p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovr |=> st_q.ovr);

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |=> st_q.err);

    p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |=> (st_q.active && (st_q.sel == $past(vec_sel)) && (st_q.tick == '0)));

    p_tick_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && !period_start) |=> (st_q.tick == $past(st_q.tick) + 1'b1));

    p_idle_no_evt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.active |-> !evt_valid);
endmodule

// File: rtl/pes_pin_state.sv
module pes_pin_state
    import pes_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      evt_valid,
    input  ev_code_e  evt_code,
    output logic      drive_val,
    output logic      drive_en,
    output cmp_mode_e cmp_mode
);
    typedef struct packed {
        logic      dval;
        logic      den;
        cmp_mode_e cmp;
    } pin_st_t;

    pin_st_t pin_d, pin_q;

    always_comb begin
        pin_d = pin_q;
        if (evt_valid) begin
            case (evt_code)
                EV_DRV_LO:  begin pin_d.dval = 1'b0; pin_d.den = 1'b1; end
                EV_DRV_HI:  begin pin_d.dval = 1'b1; pin_d.den = 1'b1; end
                EV_DRV_OFF: pin_d.den = 1'b0;
                EV_TST_HI:  pin_d.cmp = CMP_HI;
                EV_TST_LO:  pin_d.cmp = CMP_LO;
                EV_TST_Z:   pin_d.cmp = CMP_Z;
                EV_TST_END: pin_d.cmp = CMP_IDLE;
                default:    pin_d = pin_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q <= '{dval: 1'b0, den: 1'b0, cmp: CMP_IDLE};
        end else begin
            pin_q <= pin_d;
        end
    end

    assign drive_val = pin_q.dval;
    assign drive_en  = pin_q.den;
    assign cmp_mode  = pin_q.cmp;

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_valid |=> ($stable(pin_q.dval) && $stable(pin_q.den) && $stable(pin_q.cmp)));

    p_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_code == EV_DRV_OFF) |=> (!drive_en && $stable(drive_val)));

    p_cmp_keeps_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && (evt_code inside {EV_TST_HI, EV_TST_LO, EV_TST_Z, EV_TST_END}))
        |=> ($stable(drive_val) && $stable(drive_en)));
endmodule

// File: rtl/pin_event_seq.sv
module pin_event_seq
    import pes_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_we,
    input  logic [6:0]  host_addr,
    input  logic [11:0] host_wdata,
    input  logic        period_start,
    input  logic [3:0]  vernier,
    input  logic [3:0]  vec_sel,
    output logic        drive_val,
    output logic        drive_en,
    output logic [1:0]  cmp_mode,
    output logic        seq_error,
    output logic        overrun
);
    logic [ADDR_W-1:0] rd_addr;
    entry_t            rd_entry;
    logic              evt_valid;
    ev_code_e          evt_code;
    cmp_mode_e         cmp_mode_w;

    pes_seq_store i_store (
        .clk      (clk),
        .wr_en    (host_we),
        .wr_addr  (ADDR_W'(host_addr)),
        .wr_data  (ENTRY_W'(host_wdata)),
        .rd_addr  (rd_addr),
        .rd_entry (rd_entry)
    );

    pes_sequencer i_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .period_start (period_start),
        .vernier      (VERN_W'(vernier)),
        .vec_sel      (SEL_W'(vec_sel)),
        .rd_addr      (rd_addr),
        .rd_entry     (rd_entry),
        .evt_valid    (evt_valid),
        .evt_code     (evt_code),
        .seq_error    (seq_error),
        .overrun      (overrun)
    );

    pes_pin_state i_pin (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_valid (evt_valid),
        .evt_code  (evt_code),
        .drive_val (drive_val),
        .drive_en  (drive_en),
        .cmp_mode  (cmp_mode_w)
    );

    assign cmp_mode = cmp_mode_w;
endmodule

// File: tb/test_pin_event_seq.sv
module test_pin_event_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [6:0]  host_addr = '0;
    logic [11:0] host_wdata = '0;
    logic        period_start = 1'b0;
    logic [3:0]  vernier = '0;
    logic [3:0]  vec_sel = '0;
    logic        drive_val, drive_en, seq_error, overrun;
    logic [1:0]  cmp_mode;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    // model storage
    int mt [128];
    int mc [128];
    int ml [128];
    // model state
    int m_act = 0, m_sel = 0, m_idx = 0, m_tick = 0, m_v = 0, m_prev = -1;
    int m_dval = 0, m_den = 0, m_cmp = 0, m_err = 0, m_ovr = 0;

    always #10 clk = ~clk;

    pin_event_seq i_pin_event_seq (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .period_start(period_start), .vernier(vernier),
        .vec_sel(vec_sel), .drive_val(drive_val), .drive_en(drive_en),
        .cmp_mode(cmp_mode), .seq_error(seq_error), .overrun(overrun)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural reference, one step per rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_act = 0; m_idx = 0; m_tick = 0; m_prev = -1;
            m_dval = 0; m_den = 0; m_cmp = 0; m_err = 0; m_ovr = 0;
        end else if (period_start) begin
            if (m_act != 0) m_ovr = 1;
            m_act = 1; m_sel = int'(vec_sel); m_idx = 0; m_tick = 0;
            m_v = int'(vernier); m_prev = -1;
        end else if (m_act != 0) begin
            int a;
            bit bad;
            a = m_sel * 8 + m_idx;
            bad = (mc[a] == 7) || (m_prev >= 0 && mt[a] <= m_prev);
            if (bad || m_tick >= m_v + mt[a]) begin
                if (bad) m_err = 1;
                else begin
                    m_prev = mt[a];
                    case (mc[a])
                        0: begin m_dval = 0; m_den = 1; end
                        1: begin m_dval = 1; m_den = 1; end
                        2: m_den = 0;
                        3: m_cmp = 1;
                        4: m_cmp = 2;
                        5: m_cmp = 3;
                        6: m_cmp = 0;
                        default: ;
                    endcase
                end
                if (ml[a] != 0 || m_idx == 7) m_act = 0;
                else m_idx++;
            end
            m_tick++;
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R4", "drive_val(model)", int'(drive_val), m_dval);
            chk("R4", "drive_en(model)", int'(drive_en), m_den);
            chk("R5", "cmp_mode(model)", int'(cmp_mode), m_cmp);
            chk("R7", "seq_error(model)", int'(seq_error), m_err);
            chk("R8", "overrun(model)", int'(overrun), m_ovr);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic put(input int s, input int slot, input int code, input int tm, input int last);
        int a;
        a = s * 8 + slot;
        mt[a] = tm; mc[a] = code; ml[a] = last;
        @(negedge clk);
        host_we = 1'b1;
        host_addr = 7'(a);
        host_wdata = {1'(last), 3'(code), 8'(tm)};
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic start_period(input int s, input int v);
        @(negedge clk);
        period_start = 1'b1;
        vec_sel = 4'(s);
        vernier = 4'(v);
        @(negedge clk);
        period_start = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "drive_val", int'(drive_val), 0);
        chk("R1", "drive_en", int'(drive_en), 0);
        chk("R1", "cmp_mode", int'(cmp_mode), 0);
        chk("R1", "seq_error", int'(seq_error), 0);
        chk("R1", "overrun", int'(overrun), 0);

        // R2/R3: the four-edge drive waveform in sequence 1
        put(1, 0, 1, 1, 0);
        put(1, 1, 0, 8, 0);
        put(1, 2, 1, 13, 0);
        put(1, 3, 0, 18, 1);
        start_period(1, 0);
        wait_n(1); chk("R3", "val before t1", int'(drive_val), 0);
        wait_n(1); chk("R3", "val at t1", int'(drive_val), 1);
        chk("R4", "en after drive", int'(drive_en), 1);
        wait_n(6); chk("R3", "val before t8", int'(drive_val), 1);
        wait_n(1); chk("R3", "val at t8", int'(drive_val), 0);
        wait_n(5); chk("R3", "val at t13", int'(drive_val), 1);
        wait_n(5); chk("R3", "val at t18", int'(drive_val), 0);
        wait_n(5);

        // R3: vernier of 5 shifts the first edge to edge 7
        start_period(1, 5);
        wait_n(6); chk("R3", "vernier val before", int'(drive_val), 0);
        wait_n(1); chk("R3", "vernier val at", int'(drive_val), 1);
        wait_n(30);
        chk("R9", "overrun after idle starts", int'(overrun), 0);

        // R5: compare modes, drive untouched; R4 drive off
        put(2, 0, 3, 2, 0);
        put(2, 1, 5, 4, 0);
        put(2, 2, 6, 6, 0);
        put(2, 3, 4, 8, 0);
        put(2, 4, 2, 10, 1);
        start_period(2, 0);
        wait_n(3); chk("R5", "cmp high", int'(cmp_mode), 1);
        chk("R5", "drive_en kept", int'(drive_en), 1);
        wait_n(2); chk("R5", "cmp z", int'(cmp_mode), 3);
        wait_n(2); chk("R5", "cmp idle", int'(cmp_mode), 0);
        wait_n(2); chk("R5", "cmp low", int'(cmp_mode), 2);
        chk("R5", "drive_val kept", int'(drive_val), 0);
        wait_n(2); chk("R4", "drive off en", int'(drive_en), 0);
        chk("R4", "drive off val kept", int'(drive_val), 0);
        wait_n(5);

        // R7: repeated time and code 7 are skipped
        put(3, 0, 1, 3, 0);
        put(3, 1, 0, 3, 0);
        put(3, 2, 7, 5, 0);
        put(3, 3, 0, 10, 1);
        start_period(3, 0);
        wait_n(4); chk("R7", "first entry applied", int'(drive_val), 1);
        wait_n(2); chk("R7", "error raised", int'(seq_error), 1);
        chk("R7", "skipped entry no effect", int'(drive_val), 1);
        wait_n(4); chk("R7", "val before t10", int'(drive_val), 1);
        wait_n(1); chk("R7", "val at t10", int'(drive_val), 0);
        wait_n(5);
        chk("R9", "overrun still clear", int'(overrun), 0);

        // R8: a new period cuts a long sequence short
        put(4, 0, 1, 50, 0);
        put(4, 1, 0, 200, 1);
        start_period(4, 0);
        wait_n(10);
        start_period(1, 0);
        chk("R8", "overrun set", int'(overrun), 1);
        wait_n(1); chk("R8", "new seq before t1", int'(drive_val), 0);
        wait_n(1); chk("R8", "new seq at t1", int'(drive_val), 1);
        wait_n(60); chk("R8", "dropped entry never fires", int'(drive_val), 0);
        chk("R7", "error still sticky", int'(seq_error), 1);

        // R6: eight entries without a last flag, replay stops at slot 7
        for (int i = 0; i < 8; i++) begin
            put(5, i, (i == 7) ? 1 : ((i % 2 == 0) ? 1 : 0), 2 * i + 2, 0);
        end
        put(6, 0, 2, 17, 1);
        start_period(5, 0);
        wait_n(40);
        chk("R6", "stopped after slot 7 val", int'(drive_val), 1);
        chk("R6", "stopped after slot 7 en", int'(drive_en), 1);

        // R6: state carries into the next period
        put(7, 0, 3, 3, 1);
        start_period(7, 0);
        wait_n(4);
        chk("R6", "held val", int'(drive_val), 1);
        chk("R6", "held en", int'(drive_en), 1);
        chk("R6", "new cmp", int'(cmp_mode), 1);
        wait_n(5);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule